// File: doc/BRIEF.md
# Zoned Data-Memory Wait-State Controller

This block connects a processor core's data-memory request port to an asynchronous external memory bus with a 14-bit word address. Each accepted request is classified by address. It goes to one of five external zones of unequal size, to the on-chip data RAM window, or to the region set aside for memory-mapped control registers. Accesses to an external zone drive an active-low chip select together with an active-low read or write strobe. These are stretched by a wait count taken from that zone's field in a host-writable configuration register, and a one-cycle completion pulse marks the final cycle.

Hits on the on-chip RAM window or the control region never reach the external pins. They are flagged for one cycle and complete at once, and the core-side logic that owns those resources does the rest. Data travels on the upper sixteen lanes of a 24-lane bidirectional bus. The controller drives those lanes only while it writes, and it never drives the lower eight lanes.

Top module: `dmw_ctrl`

## Requirements
- R1: Addresses map to external zones as follows: zone 0 is 0x0000–0x03FF, zone 1 is 0x0400–0x07FF, zone 2 is 0x0800–0x2FFF, zone 3 is 0x3000–0x33FF and zone 4 is 0x3400–0x37FF. Each access uses the wait count of its own zone.
- R2: A request to 0x3800–0x38FF (on-chip RAM) raises `hit_int` and `rsp_done` together in the cycle after acceptance. `ext_sel_n`, `ext_rd_n` and `ext_wr_n` all stay high.
- R3: A request to 0x3900–0x3FFF (control region) raises `hit_ctrl` and `rsp_done` together in the cycle after acceptance. No select or strobe goes low.
- R4: An external access holds `ext_sel_n` low, together with `ext_rd_n` for a read or `ext_wr_n` for a write but never both, for exactly 1+N consecutive cycles. These cycles start in the cycle after acceptance, and N is the zone's wait count (0 to 7).
- R5: `rsp_done` is high for exactly one cycle: the last strobe cycle of an external access, or the single response cycle of a local hit.
- R6: `cfg_wdata` is loaded on a clock edge where `cfg_we` is high. Zone z's count occupies bits 3z+2:3z (zone 0 in bits 2:0, zone 4 in bits 14:12). The new counts govern accesses accepted after that edge.
- R7: After reset every zone's count is 7, so an external access holds its strobe for 8 cycles.
- R8: During write cycles `ext_data[23:8]` carries the request's write data. At every other time the controller leaves the bus undriven.
- R9: On a read, `ext_data[23:8]` is sampled at the end of the last strobe cycle. `rsp_rdata` holds that value from the following cycle onward.
- R10: Requests are taken only when the controller is idle. `busy` is high during every strobe cycle of an external access. A request presented while busy is dropped and never starts an access later.
- R11: `ext_addr` carries the request address and stays unchanged for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Data-memory word address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Last captured read data |
| busy | output | 1 | External access in progress |
| hit_int | output | 1 | Access hit on-chip RAM window |
| hit_ctrl | output | 1 | Access hit control region |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 15 | Packed per-zone wait counts |
| ext_addr | output | 14 | External address |
| ext_sel_n | output | 1 | External data-memory chip select, active low |
| ext_rd_n | output | 1 | Read strobe / output enable, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_data | inout | 24 | External data bus, upper 16 lanes used |

## Verification
The bench probes both sides of every zone edge and of the local windows. A decoder with one limit off by one would give the edge word the wait count of the neighbouring zone, or would wrongly send a local hit to the pins. For all eight counts it rotates a different value into each zone. A field-slicing error, or an off-by-one in the down-counter, then shows up as a strobe one cycle too long or too short, or as a completion pulse that drifts away from the last strobe cycle. It also sends a request in the middle of an access that runs with the reset count of seven. A controller that latched that request would issue a second, unrequested strobe burst or would change the address partway through.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    localparam int ADDR_W     = 14;
    localparam int DATA_W     = 16;
    localparam int BUS_W      = 24;
    localparam int WS_W       = 3;
    localparam int NZONES     = 5;
    localparam int CFG_W      = NZONES * WS_W;
    localparam int ZONE_IDX_W = $clog2(NZONES);
    localparam int PAD_W      = BUS_W - DATA_W;

    // Zone i covers [ZONE_LIMIT[i], ZONE_LIMIT[i+1]); the last entry starts on-chip RAM.
    localparam logic [ADDR_W-1:0] ZONE_LIMIT [NZONES+1] =
        '{14'h0000, 14'h0400, 14'h0800, 14'h3000, 14'h3400, 14'h3800};
    localparam logic [ADDR_W-1:0] LOCAL_RAM_END = 14'h3900;

    localparam logic [CFG_W-1:0] CFG_RESET = {NZONES{ {WS_W{1'b1}} }};

    typedef enum logic [1:0] {
        RGN_EXT,
        RGN_INT,
        RGN_CTRL
    } region_e;

    typedef struct packed {
        region_e                 region;
        logic [ZONE_IDX_W-1:0]   zone;
    } decode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_LOCAL
    } state_e;

    function automatic logic [WS_W-1:0] ws_field(input logic [CFG_W-1:0] cfg,
                                                 input logic [ZONE_IDX_W-1:0] zone);
        return cfg[zone*WS_W +: WS_W];
    endfunction

endpackage

// File: rtl/dmw_decode.sv
module dmw_decode
    import dmw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);

    logic [NZONES-1:0] hit;

    for (genvar i = 0; i < NZONES; i++) begin : g_zone
        if (i == 0) begin : g_first
            assign hit[i] = addr < ZONE_LIMIT[1];
        end else begin : g_rest
            assign hit[i] = (addr >= ZONE_LIMIT[i]) && (addr < ZONE_LIMIT[i+1]);
        end
    end

    always_comb begin
        dec.region = RGN_CTRL;
        dec.zone   = '0;
        for (int i = 0; i < NZONES; i++) begin
            if (hit[i]) begin
                dec.region = RGN_EXT;
                dec.zone   = ZONE_IDX_W'(i);
            end
        end
        if ((addr >= ZONE_LIMIT[NZONES]) && (addr < LOCAL_RAM_END)) begin
            dec.region = RGN_INT;
        end
    end

endmodule

// File: rtl/dmw_wscfg.sv
module dmw_wscfg
    import dmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            cfg <= wdata;
        end
    end

endmodule

// File: rtl/dmw_seq.sv
module dmw_seq
    import dmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  decode_t           dec,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [DATA_W-1:0] rd_bus,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              sel_act,
    output logic              rd_act,
    output logic              wr_act,
    output logic              done,
    output logic              busy,
    output logic              hit_int,
    output logic              hit_ctrl
);

    state_e            state_q;
    logic [WS_W-1:0]   cnt_q;
    logic              write_q;
    region_e           rgn_q;
    logic              last_cycle;

    assign last_cycle = (state_q == ST_EXT) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rgn_q   <= RGN_EXT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        rgn_q   <= dec.region;
                        if (dec.region == RGN_EXT) begin
                            state_q <= ST_EXT;
                            cnt_q   <= ws_field(cfg, dec.zone);
                        end else begin
                            state_q <= ST_LOCAL;
                        end
                    end
                end
                ST_EXT: begin
                    if (last_cycle) begin
                        state_q <= ST_IDLE;
                        if (!write_q) begin
                            rdata_q <= rd_bus;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_LOCAL: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign sel_act  = (state_q == ST_EXT);
    assign rd_act   = sel_act && !write_q;
    assign wr_act   = sel_act && write_q;
    assign busy     = sel_act;
    assign done     = last_cycle || (state_q == ST_LOCAL);
    assign hit_int  = (state_q == ST_LOCAL) && (rgn_q == RGN_INT);
    assign hit_ctrl = (state_q == ST_LOCAL) && (rgn_q == RGN_CTRL);

endmodule

// File: rtl/dmw_ctrl.sv
module dmw_ctrl
    import dmw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 busy,
    output logic                 hit_int,
    output logic                 hit_ctrl,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic                 ext_sel_n,
    output logic                 ext_rd_n,
    output logic                 ext_wr_n,
    inout  wire  [BUS_W-1:0]     ext_data
);

    decode_t           dec;
    logic [CFG_W-1:0]  cfg;
    logic [DATA_W-1:0] wdata_q;
    logic              sel_act;
    logic              rd_act;
    logic              wr_act;

    dmw_decode u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    dmw_wscfg u_wscfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    dmw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dec       (dec),
        .cfg       (cfg),
        .rd_bus    (ext_data[BUS_W-1:PAD_W]),
        .addr_q    (ext_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata),
        .sel_act   (sel_act),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .done      (rsp_done),
        .busy      (busy),
        .hit_int   (hit_int),
        .hit_ctrl  (hit_ctrl)
    );

    assign ext_sel_n = !sel_act;
    assign ext_rd_n  = !rd_act;
    assign ext_wr_n  = !wr_act;

    assign ext_data[BUS_W-1:PAD_W] = wr_act ? wdata_q : {DATA_W{1'bz}};
    assign ext_data[PAD_W-1:0]     = {PAD_W{1'bz}};

endmodule

// File: rtl/dmw_ctrl_chk.sv
module dmw_ctrl_chk
    import dmw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ext_sel_n,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic              busy,
    input logic              rsp_done,
    input logic              hit_int,
    input logic              hit_ctrl,
    input logic [ADDR_W-1:0] ext_addr
);

    localparam int RUN_W   = WS_W + 2;
    localparam int RUN_MAX = 1 << WS_W;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || ext_sel_n) begin
            run_q <= '0;
        end else if (run_q != '1) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_strobe_under_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd_n || !ext_wr_n) |-> !ext_sel_n);

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!ext_rd_n && !ext_wr_n));

    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(RUN_MAX));

    assert_local_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        hit_int |-> (ext_sel_n && ext_rd_n && ext_wr_n));

    assert_ctrl_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        hit_ctrl |-> (ext_sel_n && ext_rd_n && ext_wr_n && rsp_done));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_done) |=> busy);

    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !rsp_done) |=> $stable(ext_addr));

endmodule

bind dmw_ctrl dmw_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_sel_n (ext_sel_n),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n),
    .busy      (busy),
    .rsp_done  (rsp_done),
    .hit_int   (hit_int),
    .hit_ctrl  (hit_ctrl),
    .ext_addr  (ext_addr)
);

// File: tb/dmw_ctrl_tb.sv
module dmw_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        busy;
    logic        hit_int;
    logic        hit_ctrl;
    logic        cfg_we = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic [13:0] ext_addr;
    logic        ext_sel_n;
    logic        ext_rd_n;
    logic        ext_wr_n;
    wire  [23:0] ext_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [14:0] cfg_model = 15'h7FFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] rd_pat(input logic [13:0] a);
        return {a[7:0], ~a[13:6]} ^ 16'h5A3C;
    endfunction

    // external memory model answers reads on the upper lanes
    assign ext_data[23:8] = ext_rd_n ? 16'hzzzz : rd_pat(ext_addr);

    dmw_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .busy      (busy),
        .hit_int   (hit_int),
        .hit_ctrl  (hit_ctrl),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ext_addr  (ext_addr),
        .ext_sel_n (ext_sel_n),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_data  (ext_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0..4 external zone, 5 on-chip RAM, 6 control region
    function automatic int zone_of(input logic [13:0] a);
        if (a < 14'h0400) return 0;
        if (a < 14'h0800) return 1;
        if (a < 14'h3000) return 2;
        if (a < 14'h3400) return 3;
        if (a < 14'h3800) return 4;
        if (a < 14'h3900) return 5;
        return 6;
    endfunction

    task automatic write_cfg(input logic [14:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_model = v;
    endtask

    task automatic do_access(input logic [13:0] a, input logic wr, input bit inject);
        int z;
        int n;
        int len;
        int done_at;
        bit addr_ok;
        bit busy_ok;
        bit strobe_ok;
        bit data_ok;
        logic [15:0] wd;
        z = zone_of(a);
        n = (z < 5) ? int'(cfg_model[z*3 +: 3]) : 0;
        len = 0;
        done_at = 0;
        addr_ok = 1'b1;
        busy_ok = 1'b1;
        strobe_ok = 1'b1;
        data_ok = 1'b1;
        wd = {2'b10, a} ^ 16'hC3A5;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (z >= 5) begin
            chk(rsp_done === 1'b1, $sformatf("R2/R3 local done addr %0h", a), int'(rsp_done), 1);
            chk(hit_int === (z == 5), $sformatf("R2 hit_int addr %0h", a), int'(hit_int), int'(z == 5));
            chk(hit_ctrl === (z == 6), $sformatf("R3 hit_ctrl addr %0h", a), int'(hit_ctrl), int'(z == 6));
            chk(ext_sel_n && ext_rd_n && ext_wr_n && !busy,
                $sformatf("R2/R3 pins quiet addr %0h", a),
                int'({ext_sel_n, ext_rd_n, ext_wr_n, busy}), 4'b1110);
            @(negedge clk);
            chk(!rsp_done && ext_sel_n, $sformatf("R5 local done single addr %0h", a),
                int'({rsp_done, ext_sel_n}), 2'b01);
        end else begin
            for (int i = 0; i < 12 && !ext_sel_n; i++) begin
                len++;
                if (rsp_done) done_at = len;
                if (ext_addr != a) addr_ok = 1'b0;
                if (!busy) busy_ok = 1'b0;
                if (wr ? (ext_wr_n || !ext_rd_n) : (ext_rd_n || !ext_wr_n)) strobe_ok = 1'b0;
                if (wr && ext_data[23:8] != wd) data_ok = 1'b0;
                if (inject && len == 2) begin
                    req_valid = 1'b1;
                    req_addr  = 14'h0001;
                    req_write = ~wr;
                end else begin
                    req_valid = 1'b0;
                end
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(len == n + 1, $sformatf("R1/R4 strobe length zone %0d addr %0h", z, a), len, n + 1);
            chk(done_at == n + 1, $sformatf("R5 done position addr %0h", a), done_at, n + 1);
            chk(strobe_ok, $sformatf("R4 strobe kind addr %0h", a), int'(strobe_ok), 1);
            chk(addr_ok, $sformatf("R11 address held addr %0h", a), int'(ext_addr), int'(a));
            chk(busy_ok, $sformatf("R10 busy during access addr %0h", a), int'(busy_ok), 1);
            chk(!rsp_done, $sformatf("R5 done cleared addr %0h", a), int'(rsp_done), 0);
            if (wr) begin
                chk(data_ok, $sformatf("R8 write data addr %0h", a), int'(data_ok), 1);
            end else begin
                chk(rsp_rdata == rd_pat(a), $sformatf("R9 read capture addr %0h", a),
                    int'(rsp_rdata), int'(rd_pat(a)));
            end
            if (inject) begin
                bit quiet;
                quiet = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    if (!ext_sel_n || rsp_done) quiet = 1'b0;
                    @(negedge clk);
                end
                chk(quiet, "R10 request during busy dropped", int'(quiet), 1);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [13:0] edges [10];
        logic [13:0] locals [4];
        edges  = '{14'h0000, 14'h03FF, 14'h0400, 14'h07FF, 14'h0800,
                   14'h2FFF, 14'h3000, 14'h33FF, 14'h3400, 14'h37FF};
        locals = '{14'h3800, 14'h38FF, 14'h3900, 14'h3FFF};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ext_sel_n && ext_rd_n && ext_wr_n, "R7 reset pins idle",
            int'({ext_sel_n, ext_rd_n, ext_wr_n}), 3'b111);
        chk(!busy && !rsp_done && !hit_int && !hit_ctrl, "R7 reset status low",
            int'({busy, rsp_done, hit_int, hit_ctrl}), 0);
        chk(rsp_rdata == 16'h0, "R7 reset read data", int'(rsp_rdata), 0);

        // R7: reset count of seven in every zone, with a dropped request (R10)
        do_access(14'h1234, 1'b0, 1'b1);
        for (int i = 0; i < 10; i += 2) begin
            do_access(edges[i], 1'b1, 1'b0);
        end

        // R6: rotate every count value through every zone field
        for (int k = 0; k < 8; k++) begin
            logic [14:0] v;
            for (int z = 0; z < 5; z++) v[z*3 +: 3] = 3'((z + k) % 8);
            write_cfg(v);
            for (int i = 0; i < 10; i++) begin
                do_access(edges[i], logic'((i + k) % 2), 1'b0);
            end
        end

        // R2, R3: local windows at both edges, read and write
        for (int i = 0; i < 4; i++) begin
            do_access(locals[i], 1'b0, 1'b0);
            do_access(locals[i], 1'b1, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule